// File: doc/BRIEF.md
# Swizzle Context Operand Router

This block sits in the front end of a vector-prefixed processor. It holds up to seven swizzle contexts. Each context has a 17-bit schedule, a 3-bit source-operand mask and two 12-bit lane selectors, swiz_a and swiz_b. Each selector is four 3-bit lane-source codes. The block passes the selectors through unchanged and does not read the codes. Software or the decoder loads a context through a write port that takes a 3-bit index.

Every time an instruction issues, the block looks at bit 0 of each context's schedule. Each context whose bit 0 is 1 applies to that instruction. The masks and the selectors of all applying contexts are merged by bitwise OR. This lets one context supply only a mask while another supplies only selectors. The merged swiz_a is sent to the lowest-numbered source operand whose mask bit is set. The merged swiz_b goes to the next one. When the instruction is prefixed, every schedule then shifts right by one place. This includes prefixed instructions produced by context propagation. Non-prefixed instructions leave the schedules alone and never receive a swizzle.

The issue input is a one-way valid strobe with no ready signal. The block takes one issue in every cycle that issue_valid is high, so it never applies back-pressure. The result comes out as a one-cycle valid pulse on the following cycle. It has no ready either, so the consumer must take it in that cycle.

Top module: `swz_ctx_router`

## Requirements
- R1: After reset, every context is clear and opnd_valid, opnd_en and opnd_sel are zero. A prefixed issue straight after reset therefore gives no enables.
- R2: A write with wr_idx 0 to 6 loads that context's schedule, mask, swiz_a and swiz_b in one cycle. A write with wr_idx 7 changes no context.
- R3: opnd_valid is high in exactly the cycle after each cycle with issue_valid high, and low in every other cycle. opnd_en and opnd_sel are registered and change in that same cycle.
- R4: A context applies to a prefixed issue when bit 0 of its schedule is 1 at that issue. After each prefixed issue, the schedule shifts right by one and a zero enters at bit 16.
- R5: A non-prefixed issue leaves all schedules unchanged, and its result has opnd_en equal to 000.
- R6: When several contexts apply to one issue, their masks are ORed together, their swiz_a values are ORed together and their swiz_b values are ORed together.
- R7: Mask bit i (i = 0, 1, 2) selects source operand i+1. opnd_en bit i enables operand i+1. Operand i+1's selector is opnd_sel[12*i+11:12*i]. The merged swiz_a goes to the lowest set mask bit and the merged swiz_b goes to the second-lowest set mask bit.
- R8: When all three mask bits are set, operand 3 gets no swizzle: opnd_en[2] is 0 and its selector is zero. The selector of any disabled operand is zero.
- R9: When no context applies to a prefixed issue, opnd_en is 000 and opnd_sel is zero.
- R10: If a write targets a context in the same cycle as a prefixed issue, the issue uses the context's old contents. The written schedule is then stored without the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Context write strobe |
| wr_idx | input | 3 | Index of the context to write; 7 is ignored |
| wr_sched | input | 17 | Schedule to load |
| wr_mask | input | 3 | Source-operand mask to load |
| wr_swz_a | input | 12 | First swizzle selector to load |
| wr_swz_b | input | 12 | Second swizzle selector to load |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_prefixed | input | 1 | The issuing instruction is prefixed |
| opnd_valid | output | 1 | Result of the previous cycle's issue is present |
| opnd_en | output | 3 | Per-operand swizzle enable, bit i for operand i+1 |
| opnd_sel | output | 36 | Per-operand selectors, operand i+1 at bits 12*i+11:12*i |

## Verification
A schedule that shifted at the wrong time would not show up on the next issue. It would show up some prefixed issues later, when a context fires one slot early or late. For that reason the bench mixes non-prefixed and prefixed issues and follows a schedule through several issues. A wrong merged mask or a wrong steering choice shows up on opnd_en and opnd_sel in the very cycle after the issue. The bench covers all eight mask patterns, each with its own selector values, so that a swapped or dropped selector is caught. A write that loses to the shift leaves the context drained too early. That is detected two issues after the collision.

// File: rtl/swz_pkg.sv
package swz_pkg;
  parameter int SCHED_W = 17;
  parameter int MASK_W  = 3;
  parameter int SWZ_W   = 12;

  typedef struct packed {
    logic [SCHED_W-1:0] sched;
    logic [MASK_W-1:0]  mask;
    logic [SWZ_W-1:0]   swz_a;
    logic [SWZ_W-1:0]   swz_b;
  } ctx_t;
endpackage

// File: rtl/swz_ctx_slot.sv
module swz_ctx_slot
  import swz_pkg::*;
#(
  parameter int SLOT_ID = 0,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  ctx_t              wr_data,
  input  logic              shift_en,
  output logic              applies,
  output logic [MASK_W-1:0] mask,
  output logic [SWZ_W-1:0]  swz_a,
  output logic [SWZ_W-1:0]  swz_b
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SLOT_ID);

  ctx_t ctx_q;
  logic wr_hit;

  assign wr_hit  = wr_en && (wr_idx == MY_IDX);
  assign applies = ctx_q.sched[0];
  assign mask    = ctx_q.mask;
  assign swz_a   = ctx_q.swz_a;
  assign swz_b   = ctx_q.swz_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (wr_hit) begin
      ctx_q <= wr_data;
    end else if (shift_en) begin
      ctx_q.sched <= ctx_q.sched >> 1;
    end
  end

  // R4: a prefixed issue with no write shifts the schedule down by one
  a_r4_sched_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !wr_hit) |=> (ctx_q.sched == ($past(ctx_q.sched) >> 1)));

  // R5: with no prefixed issue and no write, the context holds
  a_r5_sched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !wr_hit) |=> $stable(ctx_q));

  // R10: a write is stored as written, even when a shift happens in the same cycle
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ctx_q == $past(wr_data)));
endmodule

// File: rtl/swz_ctx_merge.sv
module swz_ctx_merge
  import swz_pkg::*;
#(
  parameter int NUM_CTX = 7
) (
  input  logic [NUM_CTX-1:0] applies,
  input  logic [MASK_W-1:0]  mask_arr  [NUM_CTX],
  input  logic [SWZ_W-1:0]   swz_a_arr [NUM_CTX],
  input  logic [SWZ_W-1:0]   swz_b_arr [NUM_CTX],
  output logic [MASK_W-1:0]  mask_or,
  output logic [SWZ_W-1:0]   swz_a_or,
  output logic [SWZ_W-1:0]   swz_b_or
);
  always_comb begin
    mask_or  = '0;
    swz_a_or = '0;
    swz_b_or = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (applies[i]) begin
        mask_or  = mask_or  | mask_arr[i];
        swz_a_or = swz_a_or | swz_a_arr[i];
        swz_b_or = swz_b_or | swz_b_arr[i];
      end
    end
  end
endmodule

// File: rtl/swz_opnd_steer.sv
module swz_opnd_steer
  import swz_pkg::*;
(
  input  logic [MASK_W-1:0]       mask,
  input  logic [SWZ_W-1:0]        swz_a,
  input  logic [SWZ_W-1:0]        swz_b,
  output logic [MASK_W-1:0]       en,
  output logic [MASK_W*SWZ_W-1:0] sel
);
  localparam int RANK_W = $clog2(MASK_W + 1);

  always_comb begin
    logic [RANK_W-1:0] rank;
    rank = '0;
    en   = '0;
    sel  = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (mask[i]) begin
        if (rank == RANK_W'(0)) begin
          en[i] = 1'b1;
          sel[i*SWZ_W +: SWZ_W] = swz_a;
        end else if (rank == RANK_W'(1)) begin
          en[i] = 1'b1;
          sel[i*SWZ_W +: SWZ_W] = swz_b;
        end
        rank = rank + RANK_W'(1);
      end
    end
  end
endmodule

// File: rtl/swz_ctx_router.sv
module swz_ctx_router
  import swz_pkg::*;
#(
  parameter int NUM_CTX = 7,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [SCHED_W-1:0]       wr_sched,
  input  logic [MASK_W-1:0]        wr_mask,
  input  logic [SWZ_W-1:0]         wr_swz_a,
  input  logic [SWZ_W-1:0]         wr_swz_b,
  input  logic                     issue_valid,
  input  logic                     issue_prefixed,
  output logic                     opnd_valid,
  output logic [MASK_W-1:0]        opnd_en,
  output logic [MASK_W*SWZ_W-1:0]  opnd_sel
);
  localparam int SEL_W = MASK_W * SWZ_W;

  logic               shift_en;
  ctx_t               wr_data;
  logic [NUM_CTX-1:0] applies;
  logic [MASK_W-1:0]  mask_arr  [NUM_CTX];
  logic [SWZ_W-1:0]   swz_a_arr [NUM_CTX];
  logic [SWZ_W-1:0]   swz_b_arr [NUM_CTX];
  logic [MASK_W-1:0]  mask_or;
  logic [SWZ_W-1:0]   swz_a_or;
  logic [SWZ_W-1:0]   swz_b_or;
  logic [MASK_W-1:0]  steer_en;
  logic [SEL_W-1:0]   steer_sel;

  assign shift_en = issue_valid && issue_prefixed;
  assign wr_data  = '{sched: wr_sched, mask: wr_mask, swz_a: wr_swz_a, swz_b: wr_swz_b};

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    swz_ctx_slot #(.SLOT_ID(g), .IDX_W(IDX_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .shift_en (shift_en),
      .applies  (applies[g]),
      .mask     (mask_arr[g]),
      .swz_a    (swz_a_arr[g]),
      .swz_b    (swz_b_arr[g])
    );
  end

  swz_ctx_merge #(.NUM_CTX(NUM_CTX)) u_merge (
    .applies   (applies),
    .mask_arr  (mask_arr),
    .swz_a_arr (swz_a_arr),
    .swz_b_arr (swz_b_arr),
    .mask_or   (mask_or),
    .swz_a_or  (swz_a_or),
    .swz_b_or  (swz_b_or)
  );

  swz_opnd_steer u_steer (
    .mask  (mask_or),
    .swz_a (swz_a_or),
    .swz_b (swz_b_or),
    .en    (steer_en),
    .sel   (steer_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opnd_valid <= 1'b0;
      opnd_en    <= '0;
      opnd_sel   <= '0;
    end else begin
      opnd_valid <= issue_valid;
      if (issue_valid) begin
        opnd_en  <= issue_prefixed ? steer_en  : '0;
        opnd_sel <= issue_prefixed ? steer_sel : '0;
      end
    end
  end

  // R3: the valid pulse comes exactly one cycle after each issue
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> opnd_valid);
  a_r3_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> !opnd_valid);

  // R5: a non-prefixed issue never gets a swizzle
  a_r5_plain_no_swz: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_prefixed) |=> (opnd_en == '0));

  // R7: only operands whose merged mask bit was set get enabled
  a_r7_en_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> ((opnd_en & ~$past(mask_or)) == '0));

  // R8: at most two operands get a swizzle
  a_r8_two_max: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_valid |-> ($countones(opnd_en) <= 2));

  // R9: with no context applying, no operand is enabled
  a_r9_none_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && (applies == '0)) |=> (opnd_en == '0));
endmodule

// File: tb/swz_ctx_router_test.sv
module swz_ctx_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [16:0] wr_sched = '0;
  logic [2:0]  wr_mask = '0;
  logic [11:0] wr_swz_a = '0;
  logic [11:0] wr_swz_b = '0;
  logic        issue_valid = 1'b0;
  logic        issue_prefixed = 1'b0;
  logic        opnd_valid;
  logic [2:0]  opnd_en;
  logic [35:0] opnd_sel;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swz_ctx_router uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_sched(wr_sched), .wr_mask(wr_mask), .wr_swz_a(wr_swz_a),
    .wr_swz_b(wr_swz_b), .issue_valid(issue_valid),
    .issue_prefixed(issue_prefixed), .opnd_valid(opnd_valid),
    .opnd_en(opnd_en), .opnd_sel(opnd_sel)
  );

  // entry: {mask, expected en, code op3, code op2, code op1}; code 0 none, 1 swiz_a, 2 swiz_b
  localparam logic [11:0] VEC [8] = '{
    12'b000_000_00_00_00,
    12'b001_001_00_00_01,
    12'b010_010_00_01_00,
    12'b011_011_00_10_01,
    12'b100_100_01_00_00,
    12'b101_101_10_00_01,
    12'b110_110_10_01_00,
    12'b111_011_00_10_01
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctx(input logic [2:0] idx, input logic [16:0] s, input logic [2:0] m,
                           input logic [11:0] a, input logic [11:0] b);
    wr_en = 1'b1; wr_idx = idx; wr_sched = s; wr_mask = m; wr_swz_a = a; wr_swz_b = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic pref);
    issue_valid = 1'b1; issue_prefixed = pref;
    @(negedge clk);
    issue_valid = 1'b0; issue_prefixed = 1'b0;
  endtask

  function automatic logic [11:0] pick(input logic [1:0] code, input logic [11:0] a, input logic [11:0] b);
    return (code == 2'd1) ? a : (code == 2'd2) ? b : 12'h000;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {35'd0, opnd_valid}, 36'd0);
    check("R1 en", {33'd0, opnd_en}, 36'd0);
    check("R1 sel", opnd_sel, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(1'b1);
    check("R1 R9 empty issue", {33'd0, opnd_en}, 36'd0);

    // R7 R8: table of mask patterns through context 0
    for (int i = 0; i < 8; i++) begin
      logic [11:0] a, b, e;
      e = VEC[i];
      a = 12'h100 + 12'(i * 17);
      b = 12'h800 + 12'(i * 3);
      write_ctx(3'd0, 17'd1, e[11:9], a, b);
      issue(1'b1);
      check("R7 valid", {35'd0, opnd_valid}, 36'd1);
      check("R7 R8 en", {33'd0, opnd_en}, {33'd0, e[8:6]});
      check("R7 R8 sel", opnd_sel, {pick(e[5:4], a, b), pick(e[3:2], a, b), pick(e[1:0], a, b)});
    end

    // R3: no issue -> valid low
    @(negedge clk);
    check("R3 idle valid", {35'd0, opnd_valid}, 36'd0);

    // R2: index 7 ignored
    write_ctx(3'd7, 17'h1FFFF, 3'b111, 12'hFFF, 12'hFFF);
    issue(1'b1);
    check("R2 idx7 ignored", {33'd0, opnd_en}, 36'd0);

    // R4 R5: schedule timing with a non-prefixed issue in between
    write_ctx(3'd2, 17'b101, 3'b001, 12'h2A7, 12'h000);
    issue(1'b1);
    check("R4 first slot", {33'd0, opnd_en}, 36'd1);
    check("R2 R4 sel", opnd_sel, {24'd0, 12'h2A7});
    issue(1'b0);
    check("R5 plain valid", {35'd0, opnd_valid}, 36'd1);
    check("R5 plain en", {33'd0, opnd_en}, 36'd0);
    issue(1'b1);
    check("R4 gap slot", {33'd0, opnd_en}, 36'd0);
    issue(1'b1);
    check("R4 R5 third slot", {33'd0, opnd_en}, 36'd1);
    issue(1'b1);
    check("R4 drained", {33'd0, opnd_en}, 36'd0);

    // R6: OR merge over three contexts
    write_ctx(3'd3, 17'd1, 3'b101, 12'h000, 12'h000);
    write_ctx(3'd4, 17'd1, 3'b000, 12'h0F0, 12'h00F);
    write_ctx(3'd5, 17'd1, 3'b000, 12'h300, 12'h040);
    issue(1'b1);
    check("R6 en", {33'd0, opnd_en}, 36'b101);
    check("R6 sel", opnd_sel, {12'h04F, 12'h000, 12'h3F0});

    // R10: write and shift in the same cycle
    write_ctx(3'd1, 17'd1, 3'b010, 12'h123, 12'h000);
    wr_en = 1'b1; wr_idx = 3'd1; wr_sched = 17'b11; wr_mask = 3'b010;
    wr_swz_a = 12'h456; wr_swz_b = 12'h000;
    issue(1'b1);
    wr_en = 1'b0;
    check("R10 old contents used", opnd_sel, {12'h000, 12'h123, 12'h000});
    issue(1'b1);
    check("R10 new slot0", opnd_sel, {12'h000, 12'h456, 12'h000});
    issue(1'b1);
    check("R10 new slot1", {33'd0, opnd_en}, 36'b010);
    issue(1'b1);
    check("R10 drained", {33'd0, opnd_en}, 36'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule